// File: doc/BRIEF.md
# Shared-Bus Command Output Gate

This block sits between a bus cycle sequencer and the command pins of a bus controller. It takes the sequencer's raw active-low command lines and raw data enable, and produces the final command values, a per-pin output enable for the command drivers, and the final data enable. A single enable pin is interpreted in one of two ways, chosen by a static mode strap.

With the strap high, the block runs in relaxed mode and the enable pin is an active-low grant from an external arbiter of a shared bus. While the grant is withheld, the command pins float and data enable is forced low. When the grant arrives, the command pins are driven at once in the inactive-high state and data enable follows the sequencer immediately. A command the sequencer is asserting reaches the pins only after a fixed number of clock edges, so that address and data have settled on the shared bus. With the strap low, the block runs in fast mode and the pin is an asynchronous active-high command enable. It gates commands and data enable to their inactive values without floating anything.

The direction, address strobe and cascade strobe lines pass through untouched. The block never ends a bus cycle. Termination stays with the sequencer's ready logic.

Top module: `cmd_gate`

## Requirements
- R1: In relaxed mode (`mode_relaxed`=1), while `en_pin` is high, every bit of `cmd_oe` is 0 and `den_out` is 0, in the same cycle and without waiting for a clock edge.
- R2: In relaxed mode, as soon as `en_pin` is low, every bit of `cmd_oe` is 1 and `den_out` equals `den_raw`, without waiting for a clock edge.
- R3: In relaxed mode, after `en_pin` goes low, `cmd_out` stays all ones (inactive) through the first two rising clock edges that sample the grant low. From the third such edge on, `cmd_out` equals `cmd_raw`.
- R4: If the grant is sampled high at any rising edge, the three-edge hold restarts in full on the next grant, even if the previous hold had already run out.
- R5: In fast mode (`mode_relaxed`=0), while `en_pin` is low, `cmd_out` is all ones, `den_out` is 0 and every bit of `cmd_oe` stays 1.
- R6: In fast mode, while `en_pin` is high, `cmd_out` equals `cmd_raw` and `den_out` equals `den_raw` immediately.
- R7: `dtr_out`, `ale_out` and `mce_out` equal `dtr_raw`, `ale_raw` and `mce_raw` in every mode and for every value of `en_pin`.
- R8: Once the hold has run out in relaxed mode, `cmd_out` follows changes on `cmd_raw` without clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the grant synchronizer and hold counter advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_relaxed | input | 1 | Strap: 1 = grant mode with float, 0 = fast gating mode |
| en_pin | input | 1 | Shared enable: active-low grant (relaxed) or active-high enable (fast) |
| cmd_raw | input | NCMD | Raw active-low command lines from the sequencer |
| den_raw | input | 1 | Raw data enable from the sequencer |
| dtr_raw | input | 1 | Raw data direction |
| ale_raw | input | 1 | Raw address latch strobe |
| mce_raw | input | 1 | Raw cascade strobe |
| cmd_out | output | NCMD | Final active-low command values |
| cmd_oe | output | NCMD | Per-pin command driver enable; 0 means floating |
| den_out | output | 1 | Final data enable |
| dtr_out | output | 1 | Data direction, passed through |
| ale_out | output | 1 | Address latch strobe, passed through |
| mce_out | output | 1 | Cascade strobe, passed through |

## Verification
The bench focuses on the grant hold window. It probes the commands after the first, second and third sampled edge of a new grant. A design with an off-by-one counter would release a command one cycle early or late. The bench then withdraws the grant for one cycle after a partial hold and reasserts it. A counter that is not cleared would let commands out at once, or on the first edge. The asynchronous paths are checked a moment after the pin changes with no clock edge in between, so a design that registered the float or the fast-mode gate would show stale values. The fast-mode checks look for commands that still float instead of being driven high.

// File: rtl/cmd_gate.sv
module cmd_gate #(
  parameter int NCMD        = 5,
  parameter int SYNC_STAGES = 2,
  parameter int GRANT_EDGES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_relaxed,
  input  logic            en_pin,
  input  logic [NCMD-1:0] cmd_raw,
  input  logic            den_raw,
  input  logic            dtr_raw,
  input  logic            ale_raw,
  input  logic            mce_raw,
  output logic [NCMD-1:0] cmd_out,
  output logic [NCMD-1:0] cmd_oe,
  output logic            den_out,
  output logic            dtr_out,
  output logic            ale_out,
  output logic            mce_out
);
  localparam int HOLD = GRANT_EDGES - SYNC_STAGES;
  localparam int CW   = (HOLD < 1) ? 1 : $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   grant_on, released, gate_ok;

  assign grant_on = mode_relaxed & ~en_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], grant_on};
      if (!(&sync_q))               cnt_q <= '0;
      else if (cnt_q != CW'(HOLD))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign released = (&sync_q) & (cnt_q == CW'(HOLD));
  assign gate_ok  = mode_relaxed ? (grant_on & released) : en_pin;

  assign cmd_out = gate_ok ? cmd_raw : {NCMD{1'b1}};
  assign cmd_oe  = mode_relaxed ? {NCMD{grant_on}} : {NCMD{1'b1}};
  assign den_out = den_raw & (mode_relaxed ? grant_on : en_pin);
  assign dtr_out = dtr_raw;
  assign ale_out = ale_raw;
  assign mce_out = mce_raw;
endmodule

// File: rtl/cmd_gate_chk.sv
module cmd_gate_chk #(
  parameter int NCMD = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_relaxed,
  input logic            en_pin,
  input logic [NCMD-1:0] cmd_raw,
  input logic            den_raw,
  input logic [NCMD-1:0] cmd_out,
  input logic [NCMD-1:0] cmd_oe,
  input logic            den_out
);
  assert_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_relaxed && en_pin) |-> (cmd_oe == '0 && !den_out));

  assert_grant_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_relaxed && !en_pin) |-> (cmd_oe == '1 && den_out == den_raw));

  assert_hold_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_relaxed && $fell(en_pin)) |=> (!mode_relaxed || cmd_out == '1));

  assert_fast_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_relaxed && !en_pin) |-> (cmd_out == '1 && cmd_oe == '1 && !den_out));
endmodule

bind cmd_gate cmd_gate_chk #(.NCMD(NCMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_relaxed(mode_relaxed), .en_pin(en_pin),
  .cmd_raw(cmd_raw), .den_raw(den_raw), .cmd_out(cmd_out),
  .cmd_oe(cmd_oe), .den_out(den_out)
);

// File: tb/cmd_gate_test.sv
module cmd_gate_test;
  localparam int N = 5;
  logic clk = 0, rst_n = 0, mode_relaxed = 1, en_pin = 1;
  logic [N-1:0] cmd_raw = 5'b11110;
  logic den_raw = 1, dtr_raw = 0, ale_raw = 0, mce_raw = 0;
  logic [N-1:0] cmd_out, cmd_oe;
  logic den_out, dtr_out, ale_out, mce_out;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_gate #(.NCMD(N)) uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic edge_then_probe();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; mode_relaxed = 1; en_pin = 1; #1;
    check("R1 reset oe", 32'(cmd_oe), 0);
    check("R1 reset den", 32'(den_out), 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_grant();
    @(negedge clk); en_pin = 0; #1;
    check("R2 oe on grant", 32'(cmd_oe), 32'h1f);
    check("R2 den on grant", 32'(den_out), 1);
    check("R3 held at grant", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R3 held edge1", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R3 held edge2", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R3 released edge3", 32'(cmd_out), 32'h1e);
    cmd_raw = 5'b11101; #1;
    check("R8 tracks raw", 32'(cmd_out), 32'h1d);
    den_raw = 0; #1;
    check("R2 den follows", 32'(den_out), 0);
    den_raw = 1;
  endtask

  task automatic t_float();
    @(negedge clk); en_pin = 1; #1;
    check("R1 float oe", 32'(cmd_oe), 0);
    check("R1 float den", 32'(den_out), 0);
  endtask

  task automatic t_restart();
    @(negedge clk); en_pin = 0;
    edge_then_probe(); edge_then_probe();
    en_pin = 1;
    edge_then_probe();
    en_pin = 0; #1;
    check("R4 no early release", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R4 held edge1", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R4 held edge2", 32'(cmd_out), 32'h1f);
    edge_then_probe(); check("R4 released edge3", 32'(cmd_out), 32'h1d);
  endtask

  task automatic t_fast();
    @(negedge clk); mode_relaxed = 0; en_pin = 0; #1;
    check("R5 cmd inactive", 32'(cmd_out), 32'h1f);
    check("R5 oe driven", 32'(cmd_oe), 32'h1f);
    check("R5 den low", 32'(den_out), 0);
    en_pin = 1; #1;
    check("R6 cmd pass", 32'(cmd_out), 32'h1d);
    check("R6 den pass", 32'(den_out), 1);
    cmd_raw = 5'b01111; #1;
    check("R6 cmd follows", 32'(cmd_out), 32'h0f);
  endtask

  task automatic t_pass();
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        @(negedge clk);
        mode_relaxed = m[0]; en_pin = e[0];
        dtr_raw = ~dtr_raw; ale_raw = e[0]; mce_raw = ~m[0]; #1;
        check("R7 dtr", 32'(dtr_out), 32'(dtr_raw));
        check("R7 ale", 32'(ale_out), 32'(ale_raw));
        check("R7 mce", 32'(mce_out), 32'(mce_raw));
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_grant();
    t_float();
    t_restart();
    t_fast();
    t_pass();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule